// File: doc/BRIEF.md
# Host Mailbox Buffer with Request Handshake

This block is a shared command and response buffer sitting between an external host and an embedded acquisition processor. The host sees three byte-wide registers, picked by a 2-bit select: a buffer pointer, a data window into the buffer, and a status register that holds a request flag. To send a command, the host sets the pointer to 0 and writes the message bytes back to back. Byte 0 is the command code and byte 1 is a message tag, and the payload follows. Each data access advances the pointer by one. The host then writes the status register with the request bit and its load-enable bit both set.

The processor has its own port into the same buffer. It reads the request, writes its answer in place, and pulses a done strobe that drops the request flag. The host polls the status register until the flag reads 0. It then resets the pointer and streams the response out through the data window.

An optional counter measures how long the flag has stayed set. The counter raises a sticky timeout indication once a parameterised limit is reached. The default limit is about one second at the nominal clock.

Top module: `host_mailbox`

## Requirements
- R1: While reset is asserted, and in the cycle after reset is released, `req_flag`, `timed_out` and `h_rdata` read 0 and the pointer reads 0.
- R2: A host write to select 0 (pointer) loads the pointer from the low 7 bits of `h_wdata`. A host read of select 0 returns the pointer, zero-extended, on `h_rdata` in the next cycle.
- R3: A host write to select 1 (data) stores `h_wdata` at the pointer address and advances the pointer by one.
- R4: A host read of select 1 presents the byte at the pointer address on `h_rdata` in the next cycle and advances the pointer by one. `h_rdata` holds its value until the next host read.
- R5: The pointer wraps from 127 to 0 on a data access.
- R6: A host write to select 2 (status) with bit 1 (load enable) at 1 copies bit 0 into `req_flag`. With bit 1 at 0 the write leaves `req_flag` unchanged. A host read of select 2 returns `req_flag` in bit 0, `timed_out` in bit 2, and 0 in the other bits.
- R7: A `p_done` pulse clears `req_flag` in the next cycle. This holds even when the host writes the status register to set the flag in the same cycle.
- R8: With `p_we` at 1, `p_wdata` is stored at `p_addr`. `p_rdata` shows the byte at `p_addr` one cycle later, with the value from before any write in that cycle. If both sides write the same address in the same cycle, the host byte is kept.
- R9: `timed_out` rises after `req_flag` has been 1 for `TIMEOUT_CYCLES` consecutive cycles. It stays set until the host writes the status register with bits 1 and 0 both at 1, which also restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_we | input | 1 | Host register write strobe |
| h_re | input | 1 | Host register read strobe (ignored when `h_we` is 1) |
| h_sel | input | 2 | Register select: 0 pointer, 1 data, 2 status |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, valid the cycle after `h_re` |
| p_addr | input | 7 | Processor buffer address |
| p_we | input | 1 | Processor write enable |
| p_wdata | input | 8 | Processor write data |
| p_rdata | output | 8 | Processor read data, one cycle latency |
| p_done | input | 1 | Processor completion strobe, clears the request flag |
| req_flag | output | 1 | Request pending flag |
| timed_out | output | 1 | Sticky timeout indication |

## Verification
Assertions are checked on every cycle for the following rules:
- the pointer advances by exactly one on each data access and wraps after 127;
- a pointer write lands as written;
- a status write without load enable leaves the flag alone;
- `p_done` always leaves the flag cleared;
- the timeout can only rise while a request is pending and is cleared by a new start.

The bench's scenarios are needed for the content the host and processor actually exchange through the buffer. They also cover the one-cycle read latency on both ports, the host-wins rule on a same-address write, and the exact cycle at which the timeout rises.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_RSVD = 2'd3
  } hsel_e;

  localparam int ST_REQ_BIT = 0;
  localparam int ST_LD_BIT  = 1;
  localparam int ST_TO_BIT  = 2;
endpackage

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  // port A: host side, pointer addressed
  input  logic          a_re,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_q,
  // port B: processor side
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_q
);
  logic [DW-1:0] mem [DEPTH];

  // host write placed last so it is kept on a same-address collision
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       a_q <= '0;
    else if (a_re) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/mbox_host_if.sv
module mbox_host_if
  import mbox_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_we,
  input  logic          h_re,
  input  logic [1:0]    h_sel,
  input  logic [DW-1:0] h_wdata,
  input  logic          p_done,
  input  logic          timed_out,
  input  logic [DW-1:0] ram_q,
  output logic [AW-1:0] ptr,
  output logic          ram_we,
  output logic          ram_re,
  output logic [DW-1:0] ram_wdata,
  output logic          flag,
  output logic          start,
  output logic [DW-1:0] h_rdata
);
  hsel_e         sel;
  logic          is_wr, is_rd, data_acc, ld_wr;
  hsel_e         rsel_q;
  logic [DW-1:0] misc_q, misc_d;

  assign sel      = hsel_e'(h_sel);
  assign is_wr    = h_we;
  assign is_rd    = h_re & ~h_we;
  assign data_acc = (is_wr | is_rd) & (sel == SEL_DATA);
  assign ld_wr    = is_wr & (sel == SEL_STAT) & h_wdata[ST_LD_BIT];
  assign start    = ld_wr & h_wdata[ST_REQ_BIT];

  assign ram_we    = is_wr & (sel == SEL_DATA);
  assign ram_re    = is_rd & (sel == SEL_DATA);
  assign ram_wdata = h_wdata;

  always_ff @(posedge clk) begin
    if (rst)                            ptr <= '0;
    else if (is_wr && sel == SEL_PTR)   ptr <= h_wdata[AW-1:0];
    else if (data_acc)                  ptr <= ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (p_done) flag <= 1'b0;
    else if (ld_wr)  flag <= h_wdata[ST_REQ_BIT];
  end

  always_comb begin
    misc_d = '0;
    case (sel)
      SEL_PTR:  misc_d = DW'(ptr);
      SEL_STAT: begin
        misc_d[ST_REQ_BIT] = flag;
        misc_d[ST_TO_BIT]  = timed_out;
      end
      default:  misc_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= SEL_PTR;
      misc_q <= '0;
    end else if (is_rd) begin
      rsel_q <= sel;
      misc_q <= misc_d;
    end
  end

  assign h_rdata = (rsel_q == SEL_DATA) ? ram_q : misc_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    data_acc |=> ptr == AW'($past(ptr) + AW'(1)));                       // R3
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (data_acc && ptr == {AW{1'b1}}) |=> ptr == '0);                       // R5
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (is_wr && sel == SEL_PTR) |=> ptr == $past(h_wdata[AW-1:0]));         // R2
  AST_LD_QUAL: assert property (@(posedge clk) disable iff (rst)
    (is_wr && sel == SEL_STAT && !h_wdata[ST_LD_BIT] && !p_done) |=> $stable(flag)); // R6
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (rst)
    p_done |=> !flag);                                                    // R7
  AST_START_SETS: assert property (@(posedge clk) disable iff (rst)
    (start && !p_done) |=> flag);                                         // R6
endmodule

// File: rtl/mbox_watchdog.sv
module mbox_watchdog #(
  parameter bit TIMEOUT_EN     = 1'b1,
  parameter int TIMEOUT_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  input  logic start,
  output logic timed_out
);
  generate
    if (TIMEOUT_EN) begin : g_cnt
      localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
      logic [CW-1:0] cnt;
      logic          to_q;

      always_ff @(posedge clk) begin
        if (rst || start) begin
          cnt  <= '0;
          to_q <= 1'b0;
        end else if (flag && !to_q) begin
          if (cnt == CW'(TIMEOUT_CYCLES - 1)) to_q <= 1'b1;
          else                                cnt  <= cnt + CW'(1);
        end else if (!flag) begin
          cnt <= '0;
        end
      end
      assign timed_out = to_q;

      AST_TO_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!flag && !timed_out && !start) |=> !timed_out);                  // R9
      AST_START_CLEARS_TO: assert property (@(posedge clk) disable iff (rst)
        start |=> !timed_out);                                            // R9
    end else begin : g_none
      assign timed_out = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox #(
  parameter int DATA_W         = 8,
  parameter int DEPTH          = 128,
  parameter bit TIMEOUT_EN     = 1'b1,
  parameter int TIMEOUT_CYCLES = 50_000_000,
  localparam int AW            = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_we,
  input  logic              h_re,
  input  logic [1:0]        h_sel,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic [AW-1:0]     p_addr,
  input  logic              p_we,
  input  logic [DATA_W-1:0] p_wdata,
  output logic [DATA_W-1:0] p_rdata,
  input  logic              p_done,
  output logic              req_flag,
  output logic              timed_out
);
  logic [AW-1:0]     ptr;
  logic              ram_we, ram_re, start;
  logic [DATA_W-1:0] ram_wdata, ram_q;

  mbox_host_if #(.DW(DATA_W), .AW(AW)) u_host (
    .clk(clk), .rst(rst), .h_we(h_we), .h_re(h_re), .h_sel(h_sel),
    .h_wdata(h_wdata), .p_done(p_done), .timed_out(timed_out),
    .ram_q(ram_q), .ptr(ptr), .ram_we(ram_we), .ram_re(ram_re),
    .ram_wdata(ram_wdata), .flag(req_flag), .start(start), .h_rdata(h_rdata)
  );

  mbox_dpram #(.DW(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst),
    .a_re(ram_re), .a_we(ram_we), .a_addr(ptr), .a_wdata(ram_wdata), .a_q(ram_q),
    .b_we(p_we), .b_addr(p_addr), .b_wdata(p_wdata), .b_q(p_rdata)
  );

  mbox_watchdog #(.TIMEOUT_EN(TIMEOUT_EN), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_wd (
    .clk(clk), .rst(rst), .flag(req_flag), .start(start), .timed_out(timed_out)
  );

  initial begin
    AST_DEPTH_OK: assert (DEPTH == (1 << AW) && DATA_W >= 3 && AW <= DATA_W); // R5
  end
endmodule

// File: tb/test_host_mailbox.sv
`timescale 1ns/1ps
module test_host_mailbox;
  localparam int LIM = 40;

  logic       clk = 1'b0, rst = 1'b1;
  logic       h_we = 0, h_re = 0, p_we = 0, p_done = 0;
  logic [1:0] h_sel = 0;
  logic [7:0] h_wdata = 0, p_wdata = 0;
  logic [6:0] p_addr = 0;
  logic [7:0] h_rdata, p_rdata;
  logic       req_flag, timed_out;

  host_mailbox #(.TIMEOUT_CYCLES(LIM)) i_host_mailbox (
    .clk(clk), .rst(rst), .h_we(h_we), .h_re(h_re), .h_sel(h_sel),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .p_addr(p_addr), .p_we(p_we),
    .p_wdata(p_wdata), .p_rdata(p_rdata), .p_done(p_done),
    .req_flag(req_flag), .timed_out(timed_out)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference model
  byte unsigned m_mem [128];
  bit           m_known [128];
  int  m_ptr = 0, m_cnt = 0, m_rd = 0, m_prd = 0;
  bit  m_flag = 0, m_to = 0, rd_known = 1, p_known = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0; m_flag = 0; m_to = 0; m_cnt = 0; m_rd = 0;
      rd_known = 1; p_known = 0;
    end else begin
      bit old_flag, st, ld;
      old_flag = m_flag;
      st = 0; ld = 0;
      p_known = m_known[p_addr];
      m_prd   = m_mem[p_addr];
      if (!h_we && h_re) begin
        case (h_sel)
          2'd0: begin m_rd = m_ptr; rd_known = 1; end
          2'd1: begin m_rd = m_mem[m_ptr]; rd_known = m_known[m_ptr]; end
          2'd2: begin m_rd = (m_to ? 4 : 0) + (m_flag ? 1 : 0); rd_known = 1; end
          default: begin m_rd = 0; rd_known = 1; end
        endcase
        if (h_sel == 2'd1) m_ptr = (m_ptr + 1) % 128;
      end
      if (p_we) begin m_mem[p_addr] = p_wdata; m_known[p_addr] = 1; end
      if (h_we) begin
        case (h_sel)
          2'd0: m_ptr = h_wdata % 128;
          2'd1: begin
            m_mem[m_ptr] = h_wdata; m_known[m_ptr] = 1;
            m_ptr = (m_ptr + 1) % 128;
          end
          2'd2: begin ld = h_wdata[1]; st = h_wdata[1] & h_wdata[0]; end
          default: ;
        endcase
      end
      if (st) begin m_cnt = 0; m_to = 0; end
      else if (old_flag && !m_to) begin
        if (m_cnt == LIM - 1) m_to = 1; else m_cnt++;
      end else if (!old_flag) m_cnt = 0;
      if (p_done) m_flag = 0;
      else if (ld) m_flag = h_wdata[0];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(req_flag == m_flag, cur_req, "req_flag", req_flag, m_flag);
      check(timed_out == m_to, cur_req, "timed_out", timed_out, m_to);
      if (rd_known) check(h_rdata == m_rd[7:0], cur_req, "h_rdata", h_rdata, m_rd);
      if (p_known)  check(p_rdata == m_prd[7:0], cur_req, "p_rdata", p_rdata, m_prd);
    end
  end

  task automatic hw(input logic [1:0] s, input logic [7:0] d);
    h_we = 1; h_sel = s; h_wdata = d;
    @(negedge clk);
    h_we = 0;
  endtask

  task automatic hr(input logic [1:0] s, output logic [7:0] v);
    h_re = 1; h_sel = s;
    @(negedge clk);
    h_re = 0;
    v = h_rdata;
  endtask

  task automatic pw(input logic [6:0] a, input logic [7:0] d);
    p_we = 1; p_addr = a; p_wdata = d;
    @(negedge clk);
    p_we = 0;
  endtask

  task automatic pr(input logic [6:0] a, output logic [7:0] v);
    p_addr = a;
    @(negedge clk);
    v = p_rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_flag == 0 && timed_out == 0 && h_rdata == 0, "R1", "reset outputs",
          {req_flag, timed_out, h_rdata}, 0);
    rst = 0;
    @(negedge clk);
    hr(2'd0, v); check(v == 0, "R1", "pointer after reset", v, 0);

    // R2 pointer load and readback, upper bit dropped
    cur_req = "R2";
    hw(2'd0, 8'h05); hr(2'd0, v); check(v == 8'h05, "R2", "pointer read", v, 5);
    hw(2'd0, 8'hFF); hr(2'd0, v); check(v == 8'h7F, "R2", "pointer masked", v, 8'h7F);

    // R3 request load: command, tag, payload
    cur_req = "R3";
    hw(2'd0, 8'h00);
    for (int i = 0; i < 6; i++) hw(2'd1, 8'h11 * (i + 1));
    hr(2'd0, v); check(v == 6, "R3", "pointer after 6 writes", v, 6);
    pr(7'd0, v); check(v == 8'h11, "R3", "command byte at 0", v, 8'h11);
    pr(7'd5, v); check(v == 8'h66, "R3", "payload byte at 5", v, 8'h66);

    // R4 streaming readback
    cur_req = "R4";
    hw(2'd0, 8'h00);
    for (int i = 0; i < 6; i++) begin
      hr(2'd1, v); check(v == 8'(8'h11 * (i + 1)), "R4", "stream byte", v, 8'h11 * (i + 1));
    end
    hr(2'd0, v); check(v == 6, "R4", "pointer after 6 reads", v, 6);

    // R5 wrap
    cur_req = "R5";
    hw(2'd0, 8'd126);
    hw(2'd1, 8'hA1); hw(2'd1, 8'hA2); hw(2'd1, 8'hA3);
    hr(2'd0, v); check(v == 1, "R5", "pointer wrapped", v, 1);
    pr(7'd0, v); check(v == 8'hA3, "R5", "byte after wrap at 0", v, 8'hA3);

    // R6 load-enable qualifier
    cur_req = "R6";
    hw(2'd2, 8'h01); hr(2'd2, v); check(v == 8'h00, "R6", "set without ld ignored", v, 0);
    hw(2'd2, 8'h03); hr(2'd2, v); check(v == 8'h01, "R6", "start sets flag", v, 1);
    hw(2'd2, 8'h00); hr(2'd2, v); check(v == 8'h01, "R6", "clear without ld ignored", v, 1);
    hw(2'd2, 8'h02); hr(2'd2, v); check(v == 8'h00, "R6", "leftover flag cleared", v, 0);

    // R7 done clears, and wins over a same-cycle start
    cur_req = "R7";
    hw(2'd2, 8'h03);
    p_done = 1; @(negedge clk); p_done = 0;
    check(req_flag == 0, "R7", "done clears flag", req_flag, 0);
    p_done = 1; hw(2'd2, 8'h03); p_done = 0;
    check(req_flag == 0, "R7", "done beats start", req_flag, 0);

    // R8 processor response written in place, read by host; collision
    cur_req = "R8";
    pw(7'd2, 8'hC2); pw(7'd3, 8'hC3);
    hw(2'd0, 8'd2);
    hr(2'd1, v); check(v == 8'hC2, "R8", "host reads processor byte", v, 8'hC2);
    hr(2'd1, v); check(v == 8'hC3, "R8", "host reads next byte", v, 8'hC3);
    hw(2'd0, 8'd9);
    p_we = 1; p_addr = 7'd9; p_wdata = 8'h55;
    hw(2'd1, 8'hAA); p_we = 0;
    pr(7'd9, v); check(v == 8'hAA, "R8", "host wins collision", v, 8'hAA);

    // R9 timeout
    cur_req = "R9";
    hw(2'd2, 8'h03);
    repeat (LIM - 1) @(negedge clk);
    check(timed_out == 0, "R9", "not yet timed out", timed_out, 0);
    @(negedge clk);
    check(timed_out == 1, "R9", "timed out at limit", timed_out, 1);
    hr(2'd2, v); check(v == 8'h05, "R9", "status shows timeout", v, 5);
    p_done = 1; @(negedge clk); p_done = 0;
    repeat (3) @(negedge clk);
    check(timed_out == 1, "R9", "timeout sticky", timed_out, 1);
    hw(2'd2, 8'h03);
    check(timed_out == 0, "R9", "restart clears timeout", timed_out, 0);
    p_done = 1; @(negedge clk); p_done = 0;
    repeat (5) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule